// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two operands of `WIDTH` bits (32 by default). It is made by repeating one identical single-bit slice across the width. Each slice holds an AND gate, an OR gate and a full adder, and a small multiplexer picks one of their outputs. The carry passes from each slice to the next, from the least significant bit upward.

A two-bit operation code selects bitwise AND, bitwise OR, addition or two's-complement subtraction. For subtraction, every B bit passes through an XOR gate that acts as a programmable inverter. The same control signal also feeds the carry into bit 0, so the adder computes A + ~B + 1.

Besides the result, the block reports three flags:
- the unsigned carry out of the top slice;
- a signed overflow flag, formed from the carry into the top slice XOR the carry out of it;
- a zero flag for the result.

Top module: `bsalu_core`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals `opnd_a & opnd_b` bit by bit.
- R2: With `op_sel` = 2'b01, `result` equals `opnd_a | opnd_b` bit by bit.
- R3: With `op_sel` = 2'b10, `result` equals `opnd_a + opnd_b` modulo 2^WIDTH, and `carry_out` is bit WIDTH of the full sum.
- R4: With `op_sel` = 2'b11, `result` equals `opnd_a - opnd_b` modulo 2^WIDTH, computed as A + ~B + 1.
- R5: During subtraction, `carry_out` is 1 exactly when `opnd_a` is unsigned greater than or equal to `opnd_b`, which means no borrow.
- R6: During addition or subtraction, `overflow` is 1 exactly when the two adder inputs have the same sign and `result` has the opposite sign. For subtraction, the adder inputs are A and ~B.
- R7: For the two logic operations (`op_sel[1]` = 0), `carry_out` and `overflow` are both 0, whatever the operands.
- R8: `zero` is 1 exactly when every bit of `result` is 0, for all four operations.
- R9: With WIDTH = 4, the following two additions must give these results:
  - 4'b0111 + 4'b0100 gives 4'b1011, with `overflow` = 1 and `carry_out` = 0;
  - 4'b1100 + 4'b1010 gives 4'b0110, with `overflow` = 1 and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code: 00 AND, 01 OR, 10 ADD, 11 SUB |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected slice outputs |
| carry_out | output | 1 | Carry out of the top slice; 0 for logic operations |
| overflow | output | 1 | Signed overflow for ADD/SUB; 0 for logic operations |
| zero | output | 1 | High when all result bits are 0 |

## Verification
The block has no state, so a fault in one slice or in the chain shows at the ports as soon as the inputs settle. The signs of a fault are:
- a broken carry link corrupts every result bit above it, but only for operand pairs that actually carry through that position;
- a wrong B-invert or carry-in control shows up as an off-by-one or inverted difference, and only in subtraction;
- a wrong overflow tap shows up only when the top slice sees carries with mixed values.

The stimulus therefore includes carries that run across the full width, overflow at both sign boundaries, and the narrow-width corner cases.

// File: rtl/bsalu_pkg.sv
`timescale 1ns/1ps
package bsalu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic res;
        logic cout;
    } slice_out_t;

endpackage

// File: rtl/bsalu_slice.sv
`timescale 1ns/1ps
module bsalu_slice
    import bsalu_pkg::*;
(
    input  logic [1:0] op_sel,
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_inv,
    input  logic       carry_in,
    output logic       res_bit,
    output logic       carry_nxt
);
    logic       b_eff;
    logic       half_x;
    slice_out_t out_d;

    always_comb begin
        b_eff      = b_bit ^ b_inv;
        half_x     = a_bit ^ b_eff;
        out_d.cout = (a_bit & b_eff) | (half_x & carry_in);
        unique case (alu_op_e'(op_sel))
            OP_AND:  out_d.res = a_bit & b_bit;
            OP_OR:   out_d.res = a_bit | b_bit;
            default: out_d.res = half_x ^ carry_in;
        endcase
    end

    assign res_bit   = out_d.res;
    assign carry_nxt = out_d.cout;
endmodule

// File: rtl/bsalu_flags.sv
`timescale 1ns/1ps
module bsalu_flags #(
    parameter int WIDTH = 32
) (
    input  logic             arith_en,
    input  logic [WIDTH-1:0] res_vec,
    input  logic             carry_msb_in,
    input  logic             carry_msb_out,
    output logic             carry_flag,
    output logic             ovf_flag,
    output logic             zero_flag
);
    always_comb begin
        carry_flag = arith_en & carry_msb_out;
        ovf_flag   = arith_en & (carry_msb_in ^ carry_msb_out);
        zero_flag  = ~(|res_vec);
    end
endmodule

// File: rtl/bsalu_core.sv
`timescale 1ns/1ps
module bsalu_core
    import bsalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);
    localparam int MSB = WIDTH - 1;

    logic             sub_d;
    logic             arith_d;
    logic [WIDTH:0]   chain_d;
    logic [WIDTH-1:0] res_d;

    always_comb begin
        sub_d   = (alu_op_e'(op_sel) == OP_SUB);
        arith_d = op_sel[1];
    end

    assign chain_d[0] = sub_d;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        bsalu_slice i_slice (
            .op_sel    (op_sel),
            .a_bit     (opnd_a[gi]),
            .b_bit     (opnd_b[gi]),
            .b_inv     (sub_d),
            .carry_in  (chain_d[gi]),
            .res_bit   (res_d[gi]),
            .carry_nxt (chain_d[gi+1])
        );
    end

    bsalu_flags #(.WIDTH(WIDTH)) i_flags (
        .arith_en      (arith_d),
        .res_vec       (res_d),
        .carry_msb_in  (chain_d[MSB]),
        .carry_msb_out (chain_d[WIDTH]),
        .carry_flag    (carry_out),
        .ovf_flag      (overflow),
        .zero_flag     (zero)
    );

    assign result = res_d;
endmodule

// File: rtl/bsalu_checker.sv
`timescale 1ns/1ps
module bsalu_checker #(
    parameter int WIDTH = 32
) (
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow,
    input logic             zero
);
    logic [WIDTH:0]   sum_ref;
    logic [WIDTH-1:0] b_ref;
    logic             sgn_ovf;

    always_comb begin
        sum_ref = {1'b0, opnd_a} + {1'b0, opnd_b};
        b_ref   = (op_sel == 2'b11) ? ~opnd_b : opnd_b;
        sgn_ovf = (opnd_a[WIDTH-1] == b_ref[WIDTH-1]) &&
                  (result[WIDTH-1] != opnd_a[WIDTH-1]);

        if (op_sel == 2'b00)
            assert_and_R1: assert (result == (opnd_a & opnd_b));
        if (op_sel == 2'b01)
            assert_or_R2: assert (result == (opnd_a | opnd_b));
        if (op_sel == 2'b10)
            assert_add_R3: assert ({carry_out, result} == sum_ref);
        if (op_sel == 2'b11) begin
            assert_sub_R4: assert (result == opnd_a - opnd_b);
            assert_borrow_R5: assert (carry_out == (opnd_a >= opnd_b));
        end
        if (op_sel[1])
            assert_signed_ovf_R6: assert (overflow == sgn_ovf);
        else
            assert_logic_flags_R7: assert (!carry_out && !overflow);
        assert_zero_R8: assert (zero == (result == '0));
    end
endmodule

bind bsalu_core bsalu_checker #(.WIDTH(WIDTH)) i_bsalu_checker (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .zero      (zero)
);

// File: tb/test_bsalu_core.sv
`timescale 1ns/1ps
module test_bsalu_core;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        c;
        logic        v;
        logic        z;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0, 1'b0, 1'b0},
        '{2'b00, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
        '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},
        '{2'b01, 32'hAAAA_0000, 32'h0000_5555, 32'hAAAA_5555, 1'b0, 1'b0, 1'b0},
        '{2'b01, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
        '{2'b10, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 1'b0},
        '{2'b10, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
        '{2'b10, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
        '{2'b10, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1},
        '{2'b10, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 1'b0, 1'b0, 1'b0},
        '{2'b11, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b1, 1'b0, 1'b0},
        '{2'b11, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0},
        '{2'b11, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0},
        '{2'b11, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
        '{2'b11, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        carry_out, overflow, zero;

    logic [1:0]  op4 = 2'b10;
    logic [3:0]  a4 = '0;
    logic [3:0]  b4 = '0;
    logic [3:0]  res4;
    logic        c4, v4, z4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bsalu_core #(.WIDTH(32)) i_bsalu_core (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
    );

    bsalu_core #(.WIDTH(4)) i_bsalu_core_w4 (
        .op_sel(op4), .opnd_a(a4), .opnd_b(b4),
        .result(res4), .carry_out(c4), .overflow(v4), .zero(z4)
    );

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
    endtask

    initial begin
        // idle inputs (AND of zeros): R8 zero flag, R7 flags low
        @(negedge clk);
        chk("R1 idle result", result, 32'h0);
        chk("R8 idle zero", {31'b0, zero}, 32'h1);
        chk("R7 idle flags", {30'b0, carry_out, overflow}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b);
            chk(op_tag(VECS[i].op), result, VECS[i].res);
            if (VECS[i].op[1]) begin
                chk(VECS[i].op[0] ? "R5 carry" : "R3 carry", {31'b0, carry_out}, {31'b0, VECS[i].c});
                chk("R6 overflow", {31'b0, overflow}, {31'b0, VECS[i].v});
            end else begin
                chk("R7 flags", {30'b0, carry_out, overflow}, 32'h0);
            end
            chk("R8 zero", {31'b0, zero}, {31'b0, VECS[i].z});
        end

        // R9: narrow-width corner cases
        @(posedge clk);
        op4 = 2'b10; a4 = 4'b0111; b4 = 4'b0100;
        @(negedge clk);
        chk("R9 7+4 res", {28'b0, res4}, 32'hB);
        chk("R9 7+4 ovf", {31'b0, v4}, 32'h1);
        chk("R9 7+4 carry", {31'b0, c4}, 32'h0);
        @(posedge clk);
        a4 = 4'b1100; b4 = 4'b1010;
        @(negedge clk);
        chk("R9 -4-6 res", {28'b0, res4}, 32'h6);
        chk("R9 -4-6 ovf", {31'b0, v4}, 32'h1);
        chk("R9 -4-6 carry", {31'b0, c4}, 32'h1);

        // R5/R6: exhaustive 4-bit subtraction sweep against integer model
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                @(posedge clk);
                op4 = 2'b11; a4 = 4'(x); b4 = 4'(y);
                @(negedge clk);
                chk("R4 sweep res", {28'b0, res4}, {28'b0, 4'(x - y)});
                chk("R5 sweep carry", {31'b0, c4}, {31'b0, (x >= y)});
                chk("R6 sweep ovf", {31'b0, v4},
                    {31'b0, ((x - (x >= 8 ? 16 : 0)) - (y - (y >= 8 ? 16 : 0)) > 7) ||
                            ((x - (x >= 8 ? 16 : 0)) - (y - (y >= 8 ? 16 : 0)) < -8)});
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule